// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block is the status and control register set that sits next to a DRAM controller and records the ECC events that controller reports. The controller's ECC path gives the block a single-cycle pulse for each corrected event and for each uncorrectable event. Each pulse comes with the failing address. The block keeps a saturating counter for each class of event. It holds the address of the first uncorrectable event since the last clear, and it also holds the address of the newest corrected event. It drives an active-high level interrupt while an enabled class has a nonzero count.

Software reaches the block through a simple 32-bit register port. The port takes byte offsets on a word stride, and a read returns its data one cycle after the request. Software must first store a fixed key into the protection register before it can write to the rest of the register set. Any other value stored there locks the set again. A configuration register holds an ECC-on bit and a DRAM-generation bit, and both bits are also driven out as ports. Event pulses are counted at all times, whatever the lock state.

Top module: `ecc_err_log_regs`

## Requirements
- R1: After reset the set is locked, both counts and both interrupt enables are zero, the irq output is low, `rd_data` is zero, and the configuration register holds its reset parameter (default 0x90).
- R2: A write of 0xFC600309 to offset 0x00 unlocks the set. A write of any other value to 0x00, such as 0x039FFCF6, locks it. A read of 0x00 returns 1 while the set is unlocked and 0 while it is locked.
- R3: While the set is locked, writes to offsets 0x04 and 0x50 leave those registers unchanged.
- R4: In the configuration register at 0x04, only bit 7 (ECC on) and bit 4 (1 = DDR4, 0 = DDR3) are stored. Both bits drive the `cfg_ecc_on` and `cfg_ddr4` outputs. All other bits read 0.
- R5: Bits 23:16 of offset 0x50 count corrected events. The count stops at 255 and does not wrap.
- R6: Bits 15:12 of offset 0x50 count uncorrectable events. The count stops at 15 and does not wrap.
- R7: Offset 0x58 holds the address of the first uncorrectable event since reset or since the last clear. Offset 0x5C holds the address of the most recent corrected event.
- R8: Bit 31 of offset 0x50 is a clear control and reads back as written. While it is 1, both counts are held at zero and the uncorrectable address capture is re-armed, so the first uncorrectable event after the bit returns to 0 is captured.
- R9: Bits 1:0 of offset 0x50 are interrupt enables: bit 0 for corrected events and bit 1 for uncorrectable events. `irq` is high one cycle after an enabled class's count is nonzero, and low one cycle after no enabled class has a nonzero count.
- R10: Event pulses are counted and addresses are captured whether the set is locked or unlocked.
- R11: A read returns its data on `rd_data` one cycle after `rd_en`. Unmapped offsets such as 0x60 read 0. The address registers at 0x58 and 0x5C ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register (low two bits ignored) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| ce_pulse | input | 1 | One-cycle corrected-event pulse |
| ce_addr | input | 32 | Failing address of the corrected event |
| ue_pulse | input | 1 | One-cycle uncorrectable-event pulse |
| ue_addr | input | 32 | Failing address of the uncorrectable event |
| irq | output | 1 | Active-high level interrupt |
| cfg_ecc_on | output | 1 | Configuration bit 7 |
| cfg_ddr4 | output | 1 | Configuration bit 4 |

## Verification
Corrected events come in as a short burst of distinct addresses, so the check can show that the newest address wins. Uncorrectable events are sent the same way, so the check can show that the first address wins and that the two counters stay separate. Long unbroken trains of 300 corrected and 20 uncorrectable pulses separate saturation from wrap-around. Single events under each enable mask separate a class that is masked from one that is enabled. A clear followed by one new uncorrectable event shows that the capture was re-armed. The table of register writes and reads runs with the set locked, then unlocked, then relocked. This shows that the key gates each writable register, and that events are still counted while the set is locked.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFS_W  = 8;
  // word offsets (byte offset >> 2)
  localparam logic [OFS_W-3:0] W_KEY  = 6'h00;
  localparam logic [OFS_W-3:0] W_CFG  = 6'h01;
  localparam logic [OFS_W-3:0] W_INT  = 6'h14;
  localparam logic [OFS_W-3:0] W_UEA  = 6'h16;
  localparam logic [OFS_W-3:0] W_CEA  = 6'h17;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hFC60_0309;
  localparam int unsigned CFG_ECC_BIT  = 7;
  localparam int unsigned CFG_DDR4_BIT = 4;
  localparam int unsigned INT_CLR_BIT  = 31;
  localparam int unsigned CE_LSB = 16;
  localparam int unsigned UE_LSB = 12;
endpackage

// File: rtl/ecc_key_lock.sv
module ecc_key_lock #(
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] KEY = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  output logic          unlocked
);
  always_ff @(posedge clk) begin
    if (rst)         unlocked <= 1'b0;
    else if (key_wr) unlocked <= (key_data == KEY);
  end

  p_lock_follows_key_r2: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> (unlocked == ($past(key_data) == KEY)));
  p_lock_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !key_wr |=> $stable(unlocked));
endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)              cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP && !clr) |=> cnt == TOP);
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
  p_step_one_r6: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/ecc_addr_capture.sv
module ecc_addr_capture #(
  parameter int unsigned AW = 32,
  parameter bit KEEP_FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rearm,
  input  logic          hit,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  generate
    if (KEEP_FIRST) begin : g_first
      logic held;
      always_ff @(posedge clk) begin
        if (rst) begin
          held   <= 1'b0;
          addr_q <= '0;
        end else if (rearm) begin
          held <= 1'b0;
        end else if (hit && !held) begin
          held   <= 1'b1;
          addr_q <= addr_in;
        end
      end
      p_first_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (held && !rearm) |=> $stable(addr_q));
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (rst)      addr_q <= '0;
        else if (hit) addr_q <= addr_in;
      end
      p_last_taken_r7: assert property (@(posedge clk) disable iff (rst)
        hit |=> addr_q == $past(addr_in));
    end
  endgenerate
endmodule

// File: rtl/ecc_err_log_regs.sv
module ecc_err_log_regs
  import ecc_log_pkg::*;
#(
  parameter int unsigned CE_W = 8,
  parameter int unsigned UE_W = 4,
  parameter logic [7:0] CFG_RST = 8'h90
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ce_pulse,
  input  logic [DATA_W-1:0] ce_addr,
  input  logic              ue_pulse,
  input  logic [DATA_W-1:0] ue_addr,
  output logic              irq,
  output logic              cfg_ecc_on,
  output logic              cfg_ddr4
);
  localparam int unsigned WO_W = OFS_W - 2;

  logic [WO_W-1:0] word;
  logic unlocked;
  logic wr_key, wr_cfg, wr_int;
  logic clr_q;
  logic [1:0] irq_en;
  logic [CE_W-1:0] ce_cnt;
  logic [UE_W-1:0] ue_cnt;
  logic [DATA_W-1:0] ue_addr_q, ce_addr_q;
  logic [DATA_W-1:0] rd_mux;

  assign word   = addr[OFS_W-1:2];
  assign wr_key = wr_en && word == W_KEY;
  assign wr_cfg = wr_en && unlocked && word == W_CFG;
  assign wr_int = wr_en && unlocked && word == W_INT;

  ecc_key_lock #(.DW(DATA_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk(clk), .rst(rst), .key_wr(wr_key), .key_data(wr_data),
    .unlocked(unlocked));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_ecc_on <= CFG_RST[CFG_ECC_BIT];
      cfg_ddr4   <= CFG_RST[CFG_DDR4_BIT];
      clr_q      <= 1'b0;
      irq_en     <= 2'b00;
    end else begin
      if (wr_cfg) begin
        cfg_ecc_on <= wr_data[CFG_ECC_BIT];
        cfg_ddr4   <= wr_data[CFG_DDR4_BIT];
      end
      if (wr_int) begin
        clr_q  <= wr_data[INT_CLR_BIT];
        irq_en <= wr_data[1:0];
      end
    end
  end

  ecc_sat_counter #(.W(CE_W)) u_ce_cnt (
    .clk(clk), .rst(rst), .clr(clr_q), .inc(ce_pulse), .cnt(ce_cnt));
  ecc_sat_counter #(.W(UE_W)) u_ue_cnt (
    .clk(clk), .rst(rst), .clr(clr_q), .inc(ue_pulse), .cnt(ue_cnt));

  ecc_addr_capture #(.AW(DATA_W), .KEEP_FIRST(1'b1)) u_ue_cap (
    .clk(clk), .rst(rst), .rearm(clr_q), .hit(ue_pulse),
    .addr_in(ue_addr), .addr_q(ue_addr_q));
  ecc_addr_capture #(.AW(DATA_W), .KEEP_FIRST(1'b0)) u_ce_cap (
    .clk(clk), .rst(rst), .rearm(1'b0), .hit(ce_pulse),
    .addr_in(ce_addr), .addr_q(ce_addr_q));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (irq_en[0] && ce_cnt != '0) || (irq_en[1] && ue_cnt != '0);
  end

  always_comb begin
    rd_mux = '0;
    case (word)
      W_KEY: rd_mux[0] = unlocked;
      W_CFG: begin
        rd_mux[CFG_ECC_BIT]  = cfg_ecc_on;
        rd_mux[CFG_DDR4_BIT] = cfg_ddr4;
      end
      W_INT: begin
        rd_mux[INT_CLR_BIT]            = clr_q;
        rd_mux[CE_LSB +: CE_W]         = ce_cnt;
        rd_mux[UE_LSB +: UE_W]         = ue_cnt;
        rd_mux[1:0]                    = irq_en;
      end
      W_UEA: rd_mux = ue_addr_q;
      W_CEA: rd_mux = ce_addr_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  p_locked_cfg_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked) |=> ($stable(cfg_ecc_on) && $stable(cfg_ddr4) && $stable(irq_en)));
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (ce_cnt == '0 && ue_cnt == '0) |=> !irq);
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_en == 2'b00) |=> !irq);
endmodule

// File: tb/sim_ecc_err_log_regs.sv
module sim_ecc_err_log_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, ce_pulse = 0, ue_pulse = 0;
  logic [7:0] addr = '0;
  logic [31:0] wr_data = '0, ce_addr = '0, ue_addr = '0;
  logic [31:0] rd_data;
  logic irq, cfg_ecc_on, cfg_ddr4;
  int total = 0, bad = 0;
  logic [31:0] got;

  localparam logic [31:0] KEY = 32'hFC600309;

  always #2 clk = ~clk;

  ecc_err_log_regs u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ce_pulse(ce_pulse),
    .ce_addr(ce_addr), .ue_pulse(ue_pulse), .ue_addr(ue_addr),
    .irq(irq), .cfg_ecc_on(cfg_ecc_on), .cfg_ddr4(cfg_ddr4));

  // {is_read, offset, data_or_expected}
  localparam int NV = 14;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0},          // R2 locked after reset
    {1'b0, 8'h04, 32'h0},          // R3 locked write
    {1'b1, 8'h04, 32'h90},         // R3 unchanged
    {1'b0, 8'h50, 32'h3},          // R3 locked write
    {1'b1, 8'h50, 32'h0},          // R3 unchanged
    {1'b0, 8'h00, KEY},            // R2 unlock
    {1'b1, 8'h00, 32'h1},          // R2 reads 1
    {1'b0, 8'h04, 32'hFFFF_FF6F},  // R4 only bits 7,4 kept
    {1'b1, 8'h04, 32'h0},          // R4
    {1'b0, 8'h04, 32'h0000_0090},
    {1'b1, 8'h04, 32'h90},         // R4
    {1'b0, 8'h58, 32'h1234_5678},  // R11 read-only
    {1'b1, 8'h58, 32'h0},          // R11
    {1'b1, 8'h60, 32'h0}           // R11 unmapped
  };
  localparam string VREQ [NV] = '{"R2","R3","R3","R3","R3","R2","R2",
                                 "R4","R4","R4","R4","R11","R11","R11"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wr_data = d;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    cyc(1);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic ce(input logic [31:0] a, input int n);
    ce_pulse = 1; ce_addr = a;
    cyc(n);
    ce_pulse = 0;
  endtask

  task automatic ue(input logic [31:0] a, input int n);
    ue_pulse = 1; ue_addr = a;
    cyc(n);
    ue_pulse = 0;
  endtask

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    // R1 reset state
    chk("R1", rd_data, 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);
    chk("R1", {30'b0, cfg_ecc_on, cfg_ddr4}, 32'h3);
    rd(8'h50, got); chk("R1", got, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) begin
        rd(VEC[i][39:32], got);
        chk(VREQ[i], got, VEC[i][31:0]);
      end else begin
        wr(VEC[i][39:32], VEC[i][31:0]);
      end
    end

    // R4 output pins
    wr(8'h04, 32'h80); cyc(1);
    chk("R4", {30'b0, cfg_ecc_on, cfg_ddr4}, 32'h2);
    wr(8'h04, 32'h90);

    // R5 R7 corrected events: newest address kept
    wr(8'h50, 32'h0);
    ce(32'hA000_0010, 1); ce(32'hA000_0020, 1); ce(32'hA000_0030, 1);
    cyc(2);
    rd(8'h50, got); chk("R5", got, 32'h0003_0000);
    rd(8'h5C, got); chk("R7", got, 32'hA000_0030);
    chk("R9", {31'b0, irq}, 32'h0);  // masked
    // R6 R7 uncorrectable events: first address kept
    ue(32'hB000_0100, 1); ue(32'hB000_0200, 1);
    cyc(2);
    rd(8'h50, got); chk("R6", got, 32'h0003_2000);
    rd(8'h58, got); chk("R7", got, 32'hB000_0100);

    // R9 enables
    wr(8'h50, 32'h2); cyc(2);
    chk("R9", {31'b0, irq}, 32'h1);
    wr(8'h50, 32'h8000_0003); cyc(3);
    rd(8'h50, got); chk("R8", got, 32'h8000_0003);
    chk("R9", {31'b0, irq}, 32'h0);
    ue(32'hC0DE_0000, 1); cyc(2);
    rd(8'h50, got); chk("R8", got, 32'h8000_0003);
    wr(8'h50, 32'h1); cyc(1);
    ue(32'hB000_0300, 1); ue(32'hB000_0400, 1); cyc(2);
    rd(8'h58, got); chk("R8", got, 32'hB000_0300);
    chk("R9", {31'b0, irq}, 32'h0);  // only corrected enabled
    ce(32'hA000_0040, 1); cyc(2);
    chk("R9", {31'b0, irq}, 32'h1);

    // R5 R6 saturation
    wr(8'h50, 32'h8000_0000); cyc(2); wr(8'h50, 32'h0);
    ce(32'hA000_0050, 300); ue(32'hB000_0500, 20); cyc(2);
    rd(8'h50, got); chk("R5", got[23:16], 32'hFF);
    chk("R6", {28'b0, got[15:12]}, 32'hF);

    // R10 counting while locked
    wr(8'h50, 32'h8000_0000); cyc(2); wr(8'h50, 32'h0);
    wr(8'h00, ~KEY);
    rd(8'h00, got); chk("R2", got, 32'h0);
    ce(32'hD000_0001, 1); ue(32'hD000_0002, 1); cyc(2);
    rd(8'h50, got); chk("R10", got, 32'h0001_1000);
    rd(8'h5C, got); chk("R10", got, 32'hD000_0001);
    wr(8'h50, 32'h8000_0000); cyc(2);
    rd(8'h50, got); chk("R3", got, 32'h0001_1000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule